// File: doc/BRIEF.md
# Bit Test-Modify and Bit Scan Unit

This unit does two kinds of single-bit work on a 16- or 32-bit operand. The first kind tests one chosen bit and may also change it. The test reports the bit's original value on a carry flag. The result is the operand with that bit left alone, forced to 1, forced to 0 or inverted. The second kind is a priority scan. It searches the operand for a set bit, starting from the least significant end or from the most significant end, and reports the position it finds. A zero flag says whether any bit was set at all.

A request is one cycle with `in_valid` high. During that cycle it presents an operation code, a width select, the operand and a bit position. All outputs are registered and appear on the following cycle, marked by a one-cycle `out_valid` pulse. The two flags and the scan position are state. Each operation updates only the outputs it owns, so a test leaves the zero flag as it was and a scan leaves the carry flag as it was. Between requests every output holds its value.

Top module: `bit_probe_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. When `in_valid` is low, `result`, `carry`, `zero` and `scan_idx` keep their values.
- R2: Code 0 (test) sets `carry` to the selected operand bit and sets `result` to the operand unchanged.
- R3: Codes 1 (set), 2 (clear) and 3 (invert) set `carry` to the selected bit's original value. `result` is the operand with that bit forced to 1, forced to 0, or inverted, in that order of codes.
- R4: Code 4 (upward scan) finds the lowest set bit, writes its position to `scan_idx` and clears `zero`. `result` is the operand.
- R5: Code 5 (downward scan) finds the highest set bit, writes its position to `scan_idx` and clears `zero`. `result` is the operand.
- R6: A scan of an operand with no set bit sets `zero` to 1 and leaves `scan_idx` at its previous value.
- R7: Test codes (0 to 3, 6, 7) never change `zero`. Scan codes (4, 5) never change `carry`.
- R8: With `wide`=0, only operand bits 15:0 are used and the bit position is taken modulo 16. `result` bits 31:16 are then 0. With `wide`=1, the position is taken modulo 32 over the full operand.
- R9: Codes 6 and 7 behave exactly like code 0.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R2 to R9) |
| wide | input | 1 | 1 selects the 32-bit operand width, 0 selects 16-bit |
| operand | input | 32 | Source value |
| bit_sel | input | 5 | Bit position for the test codes |
| result | output | 32 | Modified or passed-through operand |
| carry | output | 1 | Original value of the tested bit |
| zero | output | 1 | 1 when the last scan found no set bit |
| scan_idx | output | 5 | Position found by the last scan that found a set bit |
| out_valid | output | 1 | Result strobe, one cycle after the request |

## Verification
On every cycle, the embedded properties check the strobe timing and the holding of the outputs. They also check which flag each class of operation may touch, that the tested bit reaches `carry`, that a found scan position points at a set result bit with no set bit below it for upward scans, and that the upper half of `result` stays clear in narrow mode. Exact scan positions, the direction of each scan, the values of the modified results, and the survival of `scan_idx` across zero scans and unrelated requests can only be shown by the bench's sequences of requests with known expected values.

// File: rtl/bit_probe_unit.sv
module bit_probe_unit #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                op,
  input  logic                      wide,
  input  logic [DATA_W-1:0]         operand,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  output logic [DATA_W-1:0]         result,
  output logic                      carry,
  output logic                      zero,
  output logic [$clog2(DATA_W)-1:0] scan_idx,
  output logic                      out_valid
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  localparam logic [2:0] OP_SET   = 3'd1;
  localparam logic [2:0] OP_CLEAR = 3'd2;
  localparam logic [2:0] OP_FLIP  = 3'd3;
  localparam logic [2:0] OP_UP    = 3'd4;
  localparam logic [2:0] OP_DOWN  = 3'd5;

  logic [DATA_W-1:0] src, mask, modified;
  logic [IDX_W-1:0]  bidx, lo_idx, hi_idx;
  logic              picked, any_set, is_scan;

  assign src     = wide ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};
  assign bidx    = wide ? bit_sel : {1'b0, bit_sel[IDX_W-2:0]};
  assign picked  = src[bidx];
  assign mask    = DATA_W'(1) << bidx;
  assign any_set = |src;
  assign is_scan = (op == OP_UP) || (op == OP_DOWN);

  always_comb begin
    case (op)
      OP_SET:   modified = src | mask;
      OP_CLEAR: modified = src & ~mask;
      OP_FLIP:  modified = src ^ mask;
      default:  modified = src;
    endcase
  end

  always_comb begin
    lo_idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (src[i]) lo_idx = IDX_W'(i);
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < DATA_W; i++)
      if (src[i]) hi_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      carry     <= 1'b0;
      zero      <= 1'b0;
      scan_idx  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= modified;
        if (is_scan) begin
          zero <= ~any_set;
          if (any_set) scan_idx <= (op == OP_DOWN) ? hi_idx : lo_idx;
        end else begin
          carry <= picked;
        end
      end
    end
  end

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry) && $stable(zero) && $stable(scan_idx)));
  p_carry_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_scan) |=> (carry == $past(src[bidx])));
  p_found_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_scan && any_set) |=> (!zero && result[scan_idx]));
  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_UP && any_set) |=> ((result & ((DATA_W'(1) << scan_idx) - DATA_W'(1))) == '0));
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_scan && !any_set) |=> (zero && $stable(scan_idx)));
  p_zero_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_scan) |=> $stable(zero));
  p_carry_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_scan) |=> $stable(carry));
  p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/sim_bit_probe_unit.sv
`timescale 1ns/1ps
module sim_bit_probe_unit;
  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic [31:0] src;
    logic [4:0]  sel;
    logic [31:0] res;
    logic        c;
    logic        z;
    logic [4:0]  idx;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 32'h0000_0010, 5'd4,  32'h0000_0010, 1'b1, 1'b0, 5'd0},   // R2
    '{3'd0, 1'b1, 32'h8000_0000, 5'd30, 32'h8000_0000, 1'b0, 1'b0, 5'd0},   // R2
    '{3'd1, 1'b1, 32'h0000_0000, 5'd31, 32'h8000_0000, 1'b0, 1'b0, 5'd0},   // R3 set
    '{3'd2, 1'b1, 32'hFFFF_FFFF, 5'd0,  32'hFFFF_FFFE, 1'b1, 1'b0, 5'd0},   // R3 clear
    '{3'd3, 1'b1, 32'h1234_5678, 5'd3,  32'h1234_5670, 1'b1, 1'b0, 5'd0},   // R3 invert
    '{3'd3, 1'b1, 32'h1234_5678, 5'd0,  32'h1234_5679, 1'b0, 1'b0, 5'd0},   // R3 invert
    '{3'd4, 1'b1, 32'h0010_0400, 5'd0,  32'h0010_0400, 1'b0, 1'b0, 5'd10},  // R4
    '{3'd5, 1'b1, 32'h0010_0400, 5'd0,  32'h0010_0400, 1'b0, 1'b0, 5'd20},  // R5
    '{3'd1, 1'b1, 32'h0000_0001, 5'd0,  32'h0000_0001, 1'b1, 1'b0, 5'd20},  // R3
    '{3'd4, 1'b1, 32'h0000_0000, 5'd0,  32'h0000_0000, 1'b1, 1'b1, 5'd20},  // R6 R7
    '{3'd0, 1'b1, 32'h0000_0002, 5'd1,  32'h0000_0002, 1'b1, 1'b1, 5'd20},  // R7
    '{3'd5, 1'b1, 32'h8000_0000, 5'd0,  32'h8000_0000, 1'b1, 1'b0, 5'd31},  // R5
    '{3'd1, 1'b0, 32'hABCD_0000, 5'd20, 32'h0000_0010, 1'b0, 1'b0, 5'd31},  // R8
    '{3'd0, 1'b0, 32'h0000_8000, 5'd31, 32'h0000_8000, 1'b1, 1'b0, 5'd31},  // R8
    '{3'd4, 1'b0, 32'hFFFF_0000, 5'd0,  32'h0000_0000, 1'b1, 1'b1, 5'd31},  // R8 R6
    '{3'd5, 1'b0, 32'h0001_0300, 5'd0,  32'h0000_0300, 1'b1, 1'b0, 5'd9},   // R8 R5
    '{3'd6, 1'b1, 32'h0000_0004, 5'd2,  32'h0000_0004, 1'b1, 1'b0, 5'd9},   // R9
    '{3'd7, 1'b1, 32'h0000_0000, 5'd5,  32'h0000_0000, 1'b0, 1'b0, 5'd9},   // R9
    '{3'd2, 1'b1, 32'h0000_0020, 5'd5,  32'h0000_0000, 1'b1, 1'b0, 5'd9},   // R3
    '{3'd3, 1'b0, 32'h0000_FFFF, 5'd15, 32'h0000_7FFF, 1'b1, 1'b0, 5'd9}    // R3 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  bit_sel = '0;
  logic [31:0] result;
  logic        carry, zero, out_valid;
  logic [4:0]  scan_idx;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bit_probe_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .operand(operand), .bit_sel(bit_sel), .result(result), .carry(carry),
    .zero(zero), .scan_idx(scan_idx), .out_valid(out_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; op = v.op; wide = v.wide; operand = v.src; bit_sel = v.sel;
    @(negedge clk);
    in_valid = 1'b0; operand = 32'hDEAD_BEEF; bit_sel = 5'd7;
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 result", result, 32'h0);
    check("R10 flags", {27'd0, carry, zero, out_valid, 2'd0}, 32'h0);
    check("R10 scan_idx", {27'd0, scan_idx}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no strobe idle", {31'd0, out_valid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      issue(VECS[k]);
      check($sformatf("R1 strobe v%0d", k), {31'd0, out_valid}, 32'h1);
      check($sformatf("result v%0d op%0d", k, VECS[k].op), result, VECS[k].res);
      check($sformatf("carry R2 R3 R7 v%0d", k), {31'd0, carry}, {31'd0, VECS[k].c});
      check($sformatf("zero R6 R7 v%0d", k), {31'd0, zero}, {31'd0, VECS[k].z});
      check($sformatf("scan_idx R4 R5 R6 v%0d", k), {27'd0, scan_idx}, {27'd0, VECS[k].idx});
      @(negedge clk);
      check($sformatf("R1 strobe low v%0d", k), {31'd0, out_valid}, 32'h0);
      check($sformatf("R1 hold result v%0d", k), result, VECS[k].res);
    end

    // R1: back-to-back requests, each gives its own strobe and result
    @(negedge clk);
    in_valid = 1'b1; op = 3'd4; wide = 1'b1; operand = 32'h0000_0100; bit_sel = 5'd0;
    @(negedge clk);
    check("R1 b2b first strobe", {31'd0, out_valid}, 32'h1);
    check("R4 b2b first idx", {27'd0, scan_idx}, 32'd8);
    op = 3'd5; operand = 32'h0000_0101;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b second strobe", {31'd0, out_valid}, 32'h1);
    check("R5 b2b second idx", {27'd0, scan_idx}, 32'd8);
    op = 3'd4; operand = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 idle inputs ignored idx", {27'd0, scan_idx}, 32'd8);
    check("R1 idle inputs ignored result", result, 32'h0000_0101);

    // R4 vs R5 on a single set bit at the top of the narrow half
    issue('{3'd4, 1'b0, 32'h0000_8000, 5'd0, 32'h0000_8000, 1'b1, 1'b0, 5'd15});
    check("R4 narrow top bit", {27'd0, scan_idx}, 32'd15);
    issue('{3'd5, 1'b1, 32'hFFFF_FFFF, 5'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 5'd31});
    check("R5 all ones", {27'd0, scan_idx}, 32'd31);
    issue('{3'd4, 1'b1, 32'hFFFF_FFFF, 5'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 5'd0});
    check("R4 all ones", {27'd0, scan_idx}, 32'd0);

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid result", result, 32'h0);
    check("R10 mid flags", {29'd0, carry, zero, out_valid}, 32'h0);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule